// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address sequence of a four-beat memory burst. A start address is captured when the load strobe is seen. Each later cycle with the advance strobe then steps the two least significant address bits to the next beat. The upper address bits stay frozen for the whole burst. The low bits follow one of two orders, chosen by a mode input that is expected to stay static.

- **Linear order:** the low bits count upward from the start value, modulo four.
- **Interleaved order:** the low bits are the start value XORed with a running beat count.

After the fourth beat the sequence returns to the starting address. A fresh load at any point restarts the burst from the new address.

All inputs are control strobes sampled on the rising clock edge, gated by a clock enable. There is no data stream and so no valid/ready handshake. The address output is plain: it is valid in every cycle and cannot be back-pressured. Memory access itself is outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_o` is all zeros.
- R2: A cycle with `clk_en` and `load_i` high makes `addr_o` equal `addr_i` after that edge. `load_i` wins over `adv_i` when both are high.
- R3: With `mode_i` = 0 (linear), each enabled advance without load sets the low two bits to the previous low bits plus one, modulo 4. For example, start 2 gives 2, 3, 0, 1.
- R4: With `mode_i` = 1 (interleaved), the k-th address after a load (k = 0..3) has low bits equal to start XOR k. For example, start 1 gives 1, 0, 3, 2.
- R5: The fourth advance after a load returns `addr_o` to the loaded start address.
- R6: While `clk_en` is low, `addr_o` holds its value, and `load_i`, `adv_i` and `addr_i` have no effect.
- R7: Advances never change `addr_o` above bit 1.
- R8: An enabled cycle with neither `load_i` nor `adv_i` leaves `addr_o` unchanged.
- R9: A load in the middle of a burst restarts the sequence at the new start, with beat count zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Clock enable; low freezes the block |
| load_i | input | 1 | Capture `addr_i` as the burst start |
| adv_i | input | 1 | Step to the next burst beat |
| mode_i | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The output is formed directly from registers. Every result therefore appears exactly one clock edge after the enabled cycle that causes it, with no further pipeline delay.

The bench drives each stimulus just after a falling edge. It samples `addr_o` 1 ns after the following rising edge, which is the first moment the new value is due. A held or ignored case is judged at that same point, against the value seen one cycle earlier.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_step_counter.sv
module burst_step_counter #(
  parameter int LOW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             restart,
  input  logic             step,
  output logic [LOW_W-1:0] beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat <= '0;
    else if (clk_en) begin
      if (restart)    beat <= '0;
      else if (step)  beat <= beat + 1'b1;
    end
  end
endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
  import burst_seq_pkg::*;
#(
  parameter int LOW_W = 2
) (
  input  burst_order_e     order,
  input  logic [LOW_W-1:0] start_low,
  input  logic [LOW_W-1:0] beat,
  output logic [LOW_W-1:0] low
);
  logic [LOW_W-1:0] lin_low;
  logic [LOW_W-1:0] xor_low;

  // The sum wraps naturally within LOW_W bits.
  assign lin_low = start_low + beat;

  genvar g;
  generate
    for (g = 0; g < LOW_W; g++) begin : g_xor_bit
      assign xor_low[g] = start_low[g] ^ beat[g];
    end
  endgenerate

  always_comb begin
    unique case (order)
      ORDER_XOR: low = xor_low;
      default:   low = lin_low;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int LOW_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HIGH_W = ADDR_W - LOW_W;

  logic [ADDR_W-1:0] start_q;
  logic [LOW_W-1:0]  beat;
  logic [LOW_W-1:0]  low;
  burst_order_e      order;

  assign order = burst_order_e'(mode_i);

  // Start register: captured on every enabled load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               start_q <= '0;
    else if (clk_en && load_i) start_q <= addr_i;
  end

  burst_step_counter #(.LOW_W(LOW_W)) u_beat (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (clk_en),
    .restart (load_i),
    .step    (adv_i),
    .beat    (beat)
  );

  burst_low_map #(.LOW_W(LOW_W)) u_map (
    .order     (order),
    .start_low (start_q[LOW_W-1:0]),
    .beat      (beat),
    .low       (low)
  );

  assign addr_o = {start_q[ADDR_W-1 -: HIGH_W], low};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 19,
  parameter int LOW_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              load_i,
  input logic              adv_i,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o
);
  p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && load_i) |=> addr_o == $past(addr_i));

  p_linear_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv_i && !load_i && !mode_i) |=>
      (mode_i || addr_o[LOW_W-1:0] == $past(addr_o[LOW_W-1:0]) + 1'b1));

  p_hold_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> (addr_o == $past(addr_o)) || (mode_i != $past(mode_i)));

  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !load_i) |=> addr_o[ADDR_W-1:LOW_W] == $past(addr_o[ADDR_W-1:LOW_W]));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !load_i && !adv_i) |=> (addr_o == $past(addr_o)) || (mode_i != $past(mode_i)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .clk_en (clk_en),
  .load_i (load_i),
  .adv_i  (adv_i),
  .mode_i (mode_i),
  .addr_i (addr_i),
  .addr_o (addr_o)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b0;
  logic          load_i = 1'b0;
  logic          adv_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .LOW_W(2)) i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .load_i(load_i),
    .adv_i(adv_i), .mode_i(mode_i), .addr_i(addr_i), .addr_o(addr_o)
  );

  task automatic check(input logic [AW-1:0] exp, input string req);
    n_chk++;
    if (addr_o !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  // Drive one cycle after a falling edge, sample 1 ns after the rising edge.
  task automatic cyc(input logic en, input logic ld, input logic av,
                     input logic [AW-1:0] a);
    @(negedge clk);
    clk_en = en; load_i = ld; adv_i = av; addr_i = a;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    check('0, "R1");
  endtask

  task automatic t_order(input logic m);
    logic [AW-1:0] base;
    logic [1:0]    lo;
    mode_i = m;
    for (int s = 0; s < 4; s++) begin
      base = {17'h0A5C3 + 17'(s), 2'(s)};
      cyc(1, 1, 0, base);
      check(base, "R2");
      for (int k = 1; k < 4; k++) begin
        cyc(1, 0, 1, '0);
        lo = m ? (2'(s) ^ 2'(k)) : 2'(s + k);
        check({base[AW-1:2], lo}, m ? "R4 R7" : "R3 R7");
      end
      cyc(1, 0, 1, '0);
      check(base, "R5");
    end
  endtask

  task automatic t_hold();
    logic [AW-1:0] a;
    logic [AW-1:0] held;
    mode_i = 1'b0;
    a = 19'h12345;
    cyc(1, 1, 0, a);
    cyc(1, 0, 1, '0);
    held = addr_o;
    check({a[AW-1:2], 2'(a[1:0] + 2'd1)}, "R3");
    cyc(0, 1, 1, 19'h7FFFF);
    check(held, "R6");
    cyc(0, 0, 1, '0);
    check(held, "R6");
    cyc(1, 0, 0, 19'h00001);
    check(held, "R8");
    cyc(1, 0, 0, '0);
    check(held, "R8");
  endtask

  task automatic t_restart();
    logic [AW-1:0] a;
    logic [AW-1:0] b;
    mode_i = 1'b1;
    a = 19'h40002;
    b = 19'h33331;
    cyc(1, 1, 0, a);
    cyc(1, 0, 1, '0);
    cyc(1, 0, 1, '0);
    cyc(1, 1, 1, b);
    check(b, "R9 R2");
    cyc(1, 0, 1, '0);
    check({b[AW-1:2], 2'b00}, "R9");
    cyc(1, 0, 1, '0);
    check({b[AW-1:2], 2'b11}, "R9");
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_order(1'b0);
    t_order(1'b1);
    t_hold();
    t_restart();
    cyc(0, 0, 0, '0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule